// File: doc/BRIEF.md
# Passive Serial Configuration Master

This block loads a configuration bitstream into a target device over a passive serial link. An external start command begins the cycle. The block first holds the target's active-low configuration request line low for a set minimum time and then releases it. It then waits until the target's open-drain status line reads high. After that it shifts configuration bytes out one bit at a time on a single data pin, with a serial clock that it generates itself.

Bytes arrive on a valid/ready stream. If no byte is waiting, the serial clock stays low until one arrives. When the target raises its done line, the block sends a fixed number of extra serial clocks so the target can initialize, and then reports completion.

Three conditions end the cycle with an error: the status line never goes high, the done line never rises, or status falls while shifting. A finished or failed cycle holds its result until the next start command. There is no automatic retry. A long status-low time after power-up is covered by a large status timeout.

Top module: `ps_cfg_master`

## Requirements
- R1: After reset, cfgReqN is 1, serClk is 0 and inReady, busy, cfgDone and cfgError are all 0.
- R2: A start pulse while not busy drives cfgReqN low for exactly REQ_LOW_CYCLES system clocks and then releases it high.
- R3: While cfgReqN is low, or while status has not yet been seen high, serClk stays low and inReady stays 0.
- R4: Each byte is sent least significant bit first. serData changes only while serClk is low, so it is stable during every serClk high phase and is sampled by the target on the rising edge.
- R5: Every serClk high phase lasts exactly CLK_HALF system clocks.
- R6: A byte is taken only in a cycle where both inValid and inReady are 1. When no byte is pending, serClk stays low.
- R7: Once doneIn is seen high during shifting, exactly INIT_CLOCKS further serClk rising edges are sent. After them, cfgDone is 1 and busy is 0.
- R8: If statusIn is low in a shifting cycle while doneIn is low, the cycle aborts. On the next clock cfgError is 1, and serClk and inReady are 0.
- R9: If status stays low, cfgError rises after exactly STATUS_TIMEOUT system clocks of waiting after cfgReqN is released.
- R10: If doneIn never rises, cfgError rises after exactly DONE_TIMEOUT system clocks in the shifting phase.
- R11: cfgError and cfgDone each hold until the next start. A start from the error state begins a full new cycle, starting again with cfgReqN going low.
- R12: A start pulse while busy is ignored: cfgReqN stays high and the running cycle goes on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a configuration cycle (ignored while busy) |
| inData | input | DATA_W | Configuration byte |
| inValid | input | 1 | inData holds a byte |
| inReady | output | 1 | Block takes inData this cycle if inValid is 1 |
| cfgReqN | output | 1 | Active-low configuration request to the target |
| statusIn | input | 1 | Target status line (high means ready) |
| doneIn | input | 1 | Target done line |
| serClk | output | 1 | Serial clock to the target |
| serData | output | 1 | Serial data to the target, changed while serClk is low |
| busy | output | 1 | Cycle in progress |
| cfgDone | output | 1 | Cycle finished successfully |
| cfgError | output | 1 | Cycle failed |

## Verification
The assertions check on every cycle that:
- the serial clock and inReady stay quiet while the request line is low;
- data holds still across each serial clock high phase;
- no serial clock starts without a pending bit;
- status falling during shifting leads to the error state;
- the error state persists without a start;
- a request pulse never begins while busy.

Only the bench scenarios can show the rest:
- the exact request-low width;
- least-significant-bit-first byte order, using the distinct patterns 0x01 and 0x80;
- the exact status and done timeout counts;
- the number of initialization clocks after done;
- recovery from an error through a new start.

// File: rtl/ps_cfg_pkg.sv
package ps_cfg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_REQ, ST_WAIT, ST_SHIFT, ST_INIT, ST_DONE, ST_ERR
  } cfgState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clear;     // return serial engine to idle
    logic runShift;  // shifting bytes allowed
    logic runInit;   // emit initialization clocks
  } dpCtrl_t;
endpackage

// File: rtl/ps_cfg_ctrl.sv
module ps_cfg_ctrl
  import ps_cfg_pkg::*;
#(
  parameter int REQ_LOW_CYCLES = 50,
  parameter int STATUS_TIMEOUT = 10000000,
  parameter int DONE_TIMEOUT   = 50000000
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    statusIn,
  input  logic    doneIn,
  input  logic    initDone,
  output dpCtrl_t dpCtrl,
  output logic    cfgReqN,
  output logic    busy,
  output logic    cfgDone,
  output logic    cfgError
);
  localparam int MAX_A   = (REQ_LOW_CYCLES > STATUS_TIMEOUT) ? REQ_LOW_CYCLES : STATUS_TIMEOUT;
  localparam int MAX_LIM = (MAX_A > DONE_TIMEOUT) ? MAX_A : DONE_TIMEOUT;
  localparam int CNT_W   = $clog2(MAX_LIM + 1);
  localparam logic [CNT_W-1:0] REQ_LAST  = CNT_W'(REQ_LOW_CYCLES - 1);
  localparam logic [CNT_W-1:0] STAT_LAST = CNT_W'(STATUS_TIMEOUT - 1);
  localparam logic [CNT_W-1:0] DONE_LAST = CNT_W'(DONE_TIMEOUT - 1);

  cfgState_e state, nextState;
  logic [CNT_W-1:0] cnt;
  logic timed;

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE, ST_DONE, ST_ERR: if (start) nextState = ST_REQ;
      ST_REQ:   if (cnt == REQ_LAST) nextState = ST_WAIT;
      ST_WAIT: begin
        if (statusIn)               nextState = ST_SHIFT;
        else if (cnt == STAT_LAST)  nextState = ST_ERR;
      end
      ST_SHIFT: begin
        if (doneIn)                 nextState = ST_INIT;
        else if (!statusIn)         nextState = ST_ERR;
        else if (cnt == DONE_LAST)  nextState = ST_ERR;
      end
      ST_INIT:  if (initDone) nextState = ST_DONE;
      default:  nextState = ST_IDLE;
    endcase
  end

  assign timed = (state == ST_REQ) || (state == ST_WAIT) || (state == ST_SHIFT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= nextState;
      if (!timed || nextState != state) cnt <= '0;
      else                              cnt <= cnt + 1'b1;
    end
  end

  always_comb begin
    dpCtrl.runShift = (state == ST_SHIFT) && statusIn && !doneIn;
    dpCtrl.runInit  = (state == ST_INIT);
    dpCtrl.clear    = !((state == ST_SHIFT) || (state == ST_INIT))
                      || ((state == ST_SHIFT) && (doneIn || !statusIn));
  end

  assign cfgReqN  = (state != ST_REQ);
  assign busy     = (state == ST_REQ) || (state == ST_WAIT)
                    || (state == ST_SHIFT) || (state == ST_INIT);
  assign cfgDone  = (state == ST_DONE);
  assign cfgError = (state == ST_ERR);

  // R8
  status_abort_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SHIFT) && !statusIn && !doneIn |=> cfgError);

  // R11
  error_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgError && !start |=> cfgError);

  // R12
  no_restart_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cfgReqN) |-> !$past(busy));
endmodule

// File: rtl/ps_cfg_datapath.sv
module ps_cfg_datapath
  import ps_cfg_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int CLK_HALF    = 2,
  parameter int INIT_CLOCKS = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           dpCtrl,
  input  logic [DATA_W-1:0] inData,
  input  logic              inValid,
  output logic              inReady,
  output logic              serClk,
  output logic              serData,
  output logic              initDone
);
  localparam int BITS_W = $clog2(DATA_W + 1);
  localparam int DIV_W  = (CLK_HALF > 1) ? $clog2(CLK_HALF) : 1;
  localparam int INIT_W = $clog2(INIT_CLOCKS + 2);
  localparam logic [DIV_W-1:0]  DIV_LAST = DIV_W'(CLK_HALF - 1);
  localparam logic [INIT_W-1:0] INIT_END = INIT_W'(INIT_CLOCKS);

  logic [DATA_W-1:0] shReg;
  logic [BITS_W-1:0] bitsLeft;
  logic [DIV_W-1:0]  divCnt;
  logic [INIT_W-1:0] initCnt;
  logic loadByte, running, tick;

  assign initDone = (initCnt == INIT_END);
  assign inReady  = dpCtrl.runShift && !dpCtrl.clear && (bitsLeft == '0) && !serClk;
  assign loadByte = inReady && inValid;
  assign running  = (dpCtrl.runShift && (bitsLeft != '0)) || (dpCtrl.runInit && !initDone);
  assign tick     = (divCnt == DIV_LAST);
  assign serData  = shReg[0];

  always_ff @(posedge clk) begin
    if (!rstN || dpCtrl.clear) begin
      shReg    <= '0;
      bitsLeft <= '0;
      divCnt   <= '0;
      initCnt  <= '0;
      serClk   <= 1'b0;
    end else if (loadByte) begin
      shReg    <= inData;
      bitsLeft <= BITS_W'(DATA_W);
      divCnt   <= '0;
    end else if (running) begin
      if (tick) begin
        divCnt <= '0;
        if (serClk) begin
          serClk <= 1'b0;           // falling edge: present next bit
          if (dpCtrl.runShift) begin
            shReg    <= shReg >> 1;
            bitsLeft <= bitsLeft - 1'b1;
          end else begin
            initCnt <= initCnt + 1'b1;
          end
        end else begin
          serClk <= 1'b1;           // rising edge: target samples
        end
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  // R4
  data_stable_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    serClk && $past(serClk) |-> $stable(serData));

  // R6
  no_clock_unpending_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bitsLeft == '0) && !dpCtrl.runInit && !serClk |=> !serClk);
endmodule

// File: rtl/ps_cfg_master.sv
module ps_cfg_master
  import ps_cfg_pkg::*;
#(
  parameter int DATA_W         = 8,
  parameter int CLK_HALF       = 2,
  parameter int REQ_LOW_CYCLES = 50,
  parameter int STATUS_TIMEOUT = 10000000,
  parameter int DONE_TIMEOUT   = 50000000,
  parameter int INIT_CLOCKS    = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [DATA_W-1:0] inData,
  input  logic              inValid,
  output logic              inReady,
  output logic              cfgReqN,
  input  logic              statusIn,
  input  logic              doneIn,
  output logic              serClk,
  output logic              serData,
  output logic              busy,
  output logic              cfgDone,
  output logic              cfgError
);
  dpCtrl_t dpCtrl;
  logic initDone;

  ps_cfg_ctrl #(
    .REQ_LOW_CYCLES(REQ_LOW_CYCLES),
    .STATUS_TIMEOUT(STATUS_TIMEOUT),
    .DONE_TIMEOUT  (DONE_TIMEOUT)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .statusIn(statusIn),
    .doneIn(doneIn), .initDone(initDone), .dpCtrl(dpCtrl),
    .cfgReqN(cfgReqN), .busy(busy), .cfgDone(cfgDone), .cfgError(cfgError)
  );

  ps_cfg_datapath #(
    .DATA_W(DATA_W), .CLK_HALF(CLK_HALF), .INIT_CLOCKS(INIT_CLOCKS)
  ) i_dp (
    .clk(clk), .rstN(rstN), .dpCtrl(dpCtrl), .inData(inData),
    .inValid(inValid), .inReady(inReady), .serClk(serClk),
    .serData(serData), .initDone(initDone)
  );

  // R3
  quiet_in_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cfgReqN |-> !serClk && !inReady);
endmodule

// File: tb/test_ps_cfg_master.sv
module test_ps_cfg_master;
  localparam int CLK_HALF = 2;
  localparam int REQ_LOW  = 8;
  localparam int ST_TO    = 2000;
  localparam int DONE_TO  = 20000;
  localparam int INIT_CLK = 5;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0;
  logic [7:0] inData = '0;
  logic inValid = 1'b0, statusIn = 1'b0, doneIn = 1'b0;
  logic inReady, cfgReqN, serClk, serData, busy, cfgDone, cfgError;

  int checks = 0, errors = 0;
  bit finished = 1'b0;
  logic [7:0] txMem [64];
  logic [7:0] rxMem [64];
  logic [7:0] capByte = '0;
  int rxBits = 0, riseCount = 0, hiRun = 0, hiBad = 0, hiSeen = 0;

  ps_cfg_master #(
    .CLK_HALF(CLK_HALF), .REQ_LOW_CYCLES(REQ_LOW),
    .STATUS_TIMEOUT(ST_TO), .DONE_TIMEOUT(DONE_TO), .INIT_CLOCKS(INIT_CLK)
  ) i_ps_cfg_master (
    .clk(clk), .rstN(rstN), .start(start), .inData(inData), .inValid(inValid),
    .inReady(inReady), .cfgReqN(cfgReqN), .statusIn(statusIn), .doneIn(doneIn),
    .serClk(serClk), .serData(serData), .busy(busy), .cfgDone(cfgDone),
    .cfgError(cfgError)
  );

  always #10 clk = ~clk;

  // target-side receiver: samples on rising serial clock
  always @(posedge serClk) begin
    logic [7:0] captured;
    captured = {serData, capByte[7:1]};
    capByte = captured;
    rxBits++;
    riseCount++;
    if ((rxBits & 7) == 0 && (rxBits >> 3) <= 64) rxMem[(rxBits >> 3) - 1] = captured;
  end

  // high-phase width monitor
  always @(negedge clk) begin
    if (serClk) hiRun++;
    else if (hiRun != 0) begin
      hiSeen++;
      if (hiRun != CLK_HALF) hiBad++;
      hiRun = 0;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulseStart();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic fillTx(input int n);
    for (int i = 0; i < n; i++) txMem[i] = 8'(8'h5A ^ (i * 37));
    txMem[0] = 8'h01;
    if (n > 1) txMem[1] = 8'h80;
  endtask

  task automatic feedBytes(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      inValid = 1'b1;
      inData  = txMem[i];
      while (!inReady) @(negedge clk);
      @(negedge clk);
      inValid = 1'b0;
      repeat (gap) @(negedge clk);
    end
  endtask

  task automatic testReset();
    @(negedge clk);
    check(cfgReqN === 1'b1, "R1 cfgReqN", int'(cfgReqN), 1);
    check(serClk === 1'b0 && inReady === 1'b0, "R1 serClk/inReady", int'({serClk, inReady}), 0);
    check({busy, cfgDone, cfgError} === 3'b000, "R1 flags", int'({busy, cfgDone, cfgError}), 0);
  endtask

  task automatic runNormal(input int n, input int gap, input bit poke);
    int lowCnt, bad, r0, lim;
    statusIn = 1'b0; doneIn = 1'b0;
    rxBits = 0; riseCount = 0; hiBad = 0; hiSeen = 0; hiRun = 0;
    fillTx(n);
    pulseStart();
    lowCnt = 0;
    while (!cfgReqN && lowCnt < 1000) begin lowCnt++; @(negedge clk); end
    check(lowCnt == REQ_LOW, "R2 request low width", lowCnt, REQ_LOW);
    bad = 0;
    repeat (30) begin @(negedge clk); if (serClk || inReady) bad++; end
    check(bad == 0 && riseCount == 0, "R3 quiet before status", bad + riseCount, 0);
    statusIn = 1'b1;
    feedBytes(n, gap);
    if (poke) begin
      pulseStart();
      bad = 0;
      repeat (10) begin @(negedge clk); if (!cfgReqN || !busy) bad++; end
      check(bad == 0, "R12 start ignored while busy", bad, 0);
    end
    lim = 0;
    while (rxBits < n * 8 && lim < 5000) begin lim++; @(negedge clk); end
    repeat (CLK_HALF + 2) @(negedge clk);
    r0 = riseCount;
    repeat (40) @(negedge clk);
    check(riseCount == r0 && serClk == 1'b0, "R6 stall without data", riseCount - r0, 0);
    check(rxBits == n * 8, "R4 bit count", rxBits, n * 8);
    for (int i = 0; i < n; i++)
      check(rxMem[i] === txMem[i], "R4 byte LSB first", int'(rxMem[i]), int'(txMem[i]));
    doneIn = 1'b1;
    r0 = riseCount;
    lim = 0;
    while (!cfgDone && lim < 500) begin lim++; @(negedge clk); end
    check(riseCount - r0 == INIT_CLK, "R7 init clocks", riseCount - r0, INIT_CLK);
    check(cfgDone && !busy && !cfgError, "R7 done flags", int'({cfgDone, busy, cfgError}), 4);
    check(hiBad == 0 && hiSeen > 0, "R5 high phase width", hiBad, 0);
    bad = 0;
    repeat (10) begin @(negedge clk); if (!cfgDone) bad++; end
    check(bad == 0, "R11 done holds", bad, 0);
    doneIn = 1'b0; statusIn = 1'b0;
  endtask

  task automatic testStatusDrop();
    int lim, r0;
    statusIn = 1'b0; doneIn = 1'b0;
    fillTx(1); riseCount = 0;
    pulseStart();
    while (!cfgReqN) @(negedge clk);
    statusIn = 1'b1;
    inValid = 1'b1; inData = 8'hC3;
    lim = 0;
    while (riseCount < 3 && lim < 500) begin lim++; @(negedge clk); end
    statusIn = 1'b0;
    @(negedge clk);
    check(cfgError === 1'b1, "R8 error after status drop", int'(cfgError), 1);
    check(serClk === 1'b0 && inReady === 1'b0, "R8 engine stopped", int'({serClk, inReady}), 0);
    inValid = 1'b0;
    r0 = riseCount;
    repeat (10) @(negedge clk);
    check(riseCount == r0, "R8 no clocks after abort", riseCount - r0, 0);
  endtask

  task automatic testTimeouts();
    int waitCnt, bad;
    statusIn = 1'b0; doneIn = 1'b0; riseCount = 0;
    pulseStart();
    while (!cfgReqN) @(negedge clk);
    waitCnt = 0;
    while (!cfgError && waitCnt < ST_TO + 100) begin waitCnt++; @(negedge clk); end
    check(waitCnt == ST_TO, "R9 status timeout", waitCnt, ST_TO);
    check(riseCount == 0 && !busy, "R9 no clocks", riseCount, 0);
    statusIn = 1'b1;
    bad = 0;
    repeat (20) begin @(negedge clk); if (!cfgError) bad++; end
    check(bad == 0, "R11 error holds", bad, 0);
    pulseStart();
    check(cfgReqN === 1'b0 && !cfgError, "R11 restart drives request low",
          int'(cfgReqN), 0);
    while (!cfgReqN) @(negedge clk);
    waitCnt = 0;
    while (!cfgError && waitCnt < DONE_TO + 100) begin waitCnt++; @(negedge clk); end
    check(waitCnt == DONE_TO + 1, "R10 done timeout", waitCnt, DONE_TO + 1);
    statusIn = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testReset();
    runNormal(4, 0, 1'b0);
    runNormal(6, 7, 1'b1);
    testStatusDrop();
    testTimeouts();
    runNormal(3, 3, 1'b0);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule